// File: doc/BRIEF.md
# Triggered Latency Buffer with Event Readout

The block keeps a rolling history of 8-bit amplitude samples. Every clock cycle after reset it writes the incoming sample into a 256-entry circular memory. The write address steps by one each cycle and wraps from 255 to 0. Sampling never pauses, whether or not triggers arrive and whatever the readout is doing.

When a level-1 accept pulse arrives, the block works out where the triggered event began in the history. That start address is the current write address minus a runtime latency setting, taken modulo 256. The start address and an 8-bit trigger tag are queued in a small descriptor FIFO.

A readout state machine drains the FIFO one descriptor at a time. For each event it sends 32 samples as sixteen 16-bit words to a downstream concentrator. The words are pushed with a valid/ready handshake, and the event's first and last words are flagged. If a trigger arrives while the queue is full, the trigger is discarded and a sticky overflow flag is raised.

Top module: `trig_latency_buf`

## Requirements
- R1: After synchronous reset, `out_valid` and `ovf` are 0 and the trigger tag counter is 0. No word is ever presented unless a trigger was accepted.
- R2: Take the clock edge on which `l1a` is sampled high, and let W be the address written at that edge. The event start is S = W − L mod 256, where L is the effective latency. Word k (0..15) of the event is {sample at S+2k+1, sample at S+2k}, with the earlier sample in bits 7:0.
- R3: The queue holds 8 pending events; an event that has already been popped by the readout does not count towards the 8. A trigger that arrives while the queue is full is dropped and is never read out. On that edge `ovf` goes to 1, and it stays at 1 until reset.
- R4: Each event is exactly 16 words long. `out_first` is 1 only on word 0, and `out_last` is 1 only on word 15.
- R5: `out_tag` carries, on every word of an event, the value the tag counter held when that event's trigger was seen. The counter starts at 0 and increases by 1 on every `l1a` pulse, including dropped ones.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_first`, `out_last` and `out_tag` hold their values.
- R7: The effective latency L is `lat_cfg` clamped to the range 32..224. A setting below 32 acts as 32, and a setting above 224 acts as 224.
- R8: Start address and sample addresses wrap modulo 256, so an event may straddle the 255→0 boundary.
- R9: Several pending events are read out in trigger order, while sampling continues. Each pending event uses the latency that was set when its own trigger arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | 8 | Amplitude sample written each cycle |
| l1a | input | 1 | Level-1 accept pulse, one cycle per trigger |
| lat_cfg | input | 8 | Trigger latency in samples (clamped to 32..224) |
| out_data | output | 16 | Two packed samples, earlier one in low byte |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_first | output | 1 | Word is the first of its event |
| out_last | output | 1 | Word is the last of its event |
| out_tag | output | 8 | Trigger tag of the event being sent |
| ovf | output | 1 | Sticky: a trigger was dropped on a full queue |

## Verification
The bench uses the default build: 8-bit samples, a 256-entry history, 32-sample events and an 8-entry descriptor queue. The queue is shallow, so ten back-to-back triggers with the consumer held off are enough to force a drop. The write address passes 255 within the first few hundred cycles, which puts events that straddle the wrap within easy reach. The bench drives each sample as a fixed function of its write address. Every word can therefore be predicted from the start address alone, which exposes any error in latency subtraction, clamping, byte order or queue order.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    localparam int SMP_W     = 8;
    localparam int ADDR_W    = 8;
    localparam int EVT_SMPS  = 32;
    localparam int TAG_W     = 8;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int WORD_W    = 2 * SMP_W;
    localparam int EVT_WORDS = EVT_SMPS / 2;
    localparam int IDX_W     = $clog2(EVT_SMPS);
    localparam int LAT_MIN   = EVT_SMPS;
    localparam int LAT_MAX   = DEPTH - EVT_SMPS;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SMP_W-1:0]  smp_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        addr_t start;
        tag_t  tag;
    } evt_desc_t;

    typedef enum logic [1:0] {
        RO_IDLE,
        RO_LO,
        RO_HI,
        RO_HOLD
    } ro_state_e;

    // Keep the latency inside the window where a whole event is already
    // stored at trigger time and is not yet overwritten.
    function automatic addr_t clamp_lat(input addr_t lat);
        if (int'(lat) < LAT_MIN) return addr_t'(LAT_MIN);
        if (int'(lat) > LAT_MAX) return addr_t'(LAT_MAX);
        return lat;
    endfunction
endpackage

// File: rtl/tlb_sample_ram.sv
`timescale 1ns/1ps
module tlb_sample_ram
    import tlb_pkg::*;
(
    input  logic  clk,
    input  addr_t wr_addr,
    input  smp_t  wr_data,
    input  addr_t rd_addr,
    output smp_t  rd_data
);
    smp_t mem [DEPTH];

    always_ff @(posedge clk) begin
        mem[wr_addr] <= wr_data;
        rd_data      <= mem[rd_addr];
    end
endmodule

// File: rtl/tlb_trig_queue.sv
`timescale 1ns/1ps
module tlb_trig_queue
    import tlb_pkg::*;
#(
    parameter int QDEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      l1a,
    input  addr_t     wptr,
    input  addr_t     lat_cfg,
    input  logic      pop,
    output evt_desc_t head,
    output logic      empty,
    output logic      ovf
);
    localparam int QLG = $clog2(QDEPTH);
    localparam logic [QLG:0] FULL_CNT = (QLG+1)'(QDEPTH);

    evt_desc_t       slots [QDEPTH];
    logic [QLG-1:0]  wr_idx, rd_idx;
    logic [QLG:0]    count;
    tag_t            tag_cnt;
    logic            full, push, pop_ok;
    evt_desc_t       new_desc;

    assign full   = (count == FULL_CNT);
    assign empty  = (count == '0);
    assign push   = l1a && !full;
    assign pop_ok = pop && !empty;
    assign head   = slots[rd_idx];

    always_comb begin
        new_desc.start = wptr - clamp_lat(lat_cfg);
        new_desc.tag   = tag_cnt;
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_idx] <= new_desc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx  <= '0;
            rd_idx  <= '0;
            count   <= '0;
            tag_cnt <= '0;
            ovf     <= 1'b0;
        end else begin
            if (l1a)          tag_cnt <= tag_cnt + tag_t'(1);
            if (push)         wr_idx  <= wr_idx + 1'b1;
            if (pop_ok)       rd_idx  <= rd_idx + 1'b1;
            if (l1a && full)  ovf     <= 1'b1;
            count <= count + {{QLG{1'b0}}, push} - {{QLG{1'b0}}, pop_ok};
        end
    end

    p_drop_keeps_count_r3: assert property (@(posedge clk) disable iff (rst)
        (l1a && full && !pop_ok) |=> (count == $past(count)));
    p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
        (l1a && full) |=> ovf);
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);
    p_tag_step_r5: assert property (@(posedge clk) disable iff (rst)
        l1a |=> (tag_cnt == tag_t'($past(tag_cnt) + tag_t'(1))));
endmodule

// File: rtl/tlb_readout.sv
`timescale 1ns/1ps
module tlb_readout
    import tlb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      empty,
    input  evt_desc_t head,
    output logic      pop,
    output addr_t     rd_addr,
    input  smp_t      rd_data,
    output word_t     out_data,
    output logic      out_valid,
    input  logic      out_ready,
    output logic      out_first,
    output logic      out_last,
    output tag_t      out_tag
);
    ro_state_e        state;
    addr_t            base;
    logic [IDX_W-1:0] idx;
    smp_t             lo_byte;
    tag_t             tag_q;

    assign pop = (state == RO_IDLE) && !empty;

    always_comb begin
        case (state)
            RO_IDLE: rd_addr = head.start;
            RO_LO:   rd_addr = base + addr_t'(idx) + addr_t'(1);
            default: rd_addr = base + addr_t'(idx);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RO_IDLE;
            base      <= '0;
            idx       <= '0;
            lo_byte   <= '0;
            tag_q     <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_tag   <= '0;
        end else begin
            case (state)
                RO_IDLE: begin
                    if (!empty) begin
                        base  <= head.start;
                        tag_q <= head.tag;
                        idx   <= '0;
                        state <= RO_LO;
                    end
                end
                RO_LO: begin
                    lo_byte <= rd_data;
                    state   <= RO_HI;
                end
                RO_HI: begin
                    out_data  <= {rd_data, lo_byte};
                    out_valid <= 1'b1;
                    out_first <= (idx == '0);
                    out_last  <= (idx == IDX_W'(EVT_SMPS - 2));
                    out_tag   <= tag_q;
                    idx       <= idx + IDX_W'(2);
                    state     <= RO_HOLD;
                end
                default: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        state     <= out_last ? RO_IDLE : RO_LO;
                    end
                end
            endcase
        end
    end

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_first) && $stable(out_last) && $stable(out_tag)));
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_first && out_last));
    p_idle_after_last_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && state == RO_IDLE));
endmodule

// File: rtl/trig_latency_buf.sv
`timescale 1ns/1ps
module trig_latency_buf
    import tlb_pkg::*;
#(
    parameter int QDEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              l1a,
    input  logic [ADDR_W-1:0] lat_cfg,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_first,
    output logic              out_last,
    output logic [TAG_W-1:0]  out_tag,
    output logic              ovf
);
    addr_t     wptr;
    addr_t     rd_addr;
    smp_t      rd_data;
    evt_desc_t head;
    logic      empty, pop;

    always_ff @(posedge clk) begin
        if (rst) wptr <= '0;
        else     wptr <= wptr + addr_t'(1);
    end

    tlb_sample_ram u_ram (
        .clk     (clk),
        .wr_addr (wptr),
        .wr_data (smp_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    tlb_trig_queue #(.QDEPTH(QDEPTH)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .l1a     (l1a),
        .wptr    (wptr),
        .lat_cfg (lat_cfg),
        .pop     (pop),
        .head    (head),
        .empty   (empty),
        .ovf     (ovf)
    );

    tlb_readout u_ro (
        .clk       (clk),
        .rst       (rst),
        .empty     (empty),
        .head      (head),
        .pop       (pop),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_first (out_first),
        .out_last  (out_last),
        .out_tag   (out_tag)
    );

    p_wptr_step_r9: assert property (@(posedge clk) disable iff (rst)
        (wptr != {ADDR_W{1'b1}}) |=> (wptr == addr_t'($past(wptr) + addr_t'(1))));
    p_wptr_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (wptr == {ADDR_W{1'b1}}) |=> (wptr == '0));
endmodule

// File: tb/sim_trig_latency_buf.sv
`timescale 1ns/1ps
module sim_trig_latency_buf;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        l1a = 1'b0;
    logic        out_ready = 1'b0;
    logic [7:0]  lat_cfg = 8'd40;
    logic [7:0]  smp_data;
    logic [15:0] out_data;
    logic        out_valid, out_first, out_last, ovf;
    logic [7:0]  out_tag;
    logic [7:0]  wcnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] tcount = 8'd0;
    logic [7:0] q_start [0:31];
    logic [7:0] q_tag   [0:31];
    int q_wr = 0;
    int q_rd = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) wcnt <= 8'd0;
        else     wcnt <= wcnt + 8'd1;
    end
    assign smp_data = wcnt * 8'd7 + 8'd3;

    trig_latency_buf u0 (
        .clk(clk), .rst(rst), .smp_data(smp_data), .l1a(l1a), .lat_cfg(lat_cfg),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_first(out_first), .out_last(out_last), .out_tag(out_tag), .ovf(ovf)
    );

    function automatic logic [7:0] smp_of(input logic [7:0] a);
        return a * 8'd7 + 8'd3;
    endfunction

    function automatic logic [7:0] lat_eff(input logic [7:0] l);
        if (l < 8'd32)  return 8'd32;
        if (l > 8'd224) return 8'd224;
        return l;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic fire(input logic [7:0] lat, input bit kept);
        @(negedge clk);
        lat_cfg = lat;
        l1a = 1'b1;
        if (kept) begin
            q_start[q_wr] = wcnt - lat_eff(lat);
            q_tag[q_wr]   = tcount;
            q_wr++;
        end
        tcount = tcount + 8'd1;
        @(negedge clk);
        l1a = 1'b0;
    endtask

    task automatic read_event(input bit stall, input string rq);
        logic [7:0] st, tg;
        st = q_start[q_rd];
        tg = q_tag[q_rd];
        q_rd++;
        for (int k = 0; k < 16; k++) begin
            int waitc;
            logic [7:0] a;
            logic [15:0] exp_w;
            waitc = 0;
            @(negedge clk);
            while (!out_valid && waitc < 2000) begin
                @(negedge clk);
                waitc++;
            end
            check(waitc < 2000, rq, "word timeout", waitc, k);
            a = st + 8'(2 * k);
            exp_w = {smp_of(a + 8'd1), smp_of(a)};
            check(out_data == exp_w, rq, "data", out_data, exp_w);
            check(out_first == (k == 0) && out_last == (k == 15), "R4", "first/last",
                  {out_first, out_last}, {k == 0, k == 15});
            check(out_tag == tg, "R5", "tag", out_tag, tg);
            if (stall) begin
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    check(out_valid && out_data == exp_w && out_tag == tg &&
                          out_first == (k == 0) && out_last == (k == 15),
                          "R6", "held word", out_data, exp_w);
                end
            end
            out_ready = 1'b1;
            @(posedge clk);
            #1 out_ready = 1'b0;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        check(ovf == 1'b0, "R1", "ovf after reset", ovf, 0);
        repeat (300) begin
            @(negedge clk);
            if (out_valid) check(0, "R1", "word without trigger", out_valid, 0);
        end
        check(out_valid == 1'b0, "R1", "idle without trigger", out_valid, 0);
    endtask

    task automatic t_basic();
        fire(8'd40, 1);
        read_event(0, "R2");
    endtask

    task automatic t_clamp();
        fire(8'd5, 1);   read_event(0, "R7");
        fire(8'd250, 1); read_event(0, "R7");
        fire(8'd32, 1);  read_event(0, "R7");
        fire(8'd224, 1); read_event(0, "R7");
    endtask

    task automatic t_wrap();
        while (wcnt != 8'd10) @(negedge clk);
        fire(8'd40, 1);
        check(q_start[q_wr-1] > 8'd224, "R8", "start near top", q_start[q_wr-1], 225);
        read_event(0, "R8");
    endtask

    task automatic t_stall();
        fire(8'd60, 1);
        read_event(1, "R6");
    endtask

    task automatic t_order();
        fire(8'd40, 1);
        repeat (20) @(negedge clk);
        fire(8'd100, 1);
        fire(8'd33, 1);
        read_event(0, "R9");
        read_event(0, "R9");
        read_event(0, "R9");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) fire(8'd50, 1);
        check(ovf == 1'b0, "R3", "ovf before drop", ovf, 0);
        fire(8'd50, 0);
        check(ovf == 1'b1, "R3", "ovf after drop", ovf, 1);
        for (int i = 0; i < 9; i++) read_event(0, "R3");
        repeat (300) begin
            @(negedge clk);
            if (out_valid) check(0, "R3", "dropped event read out", out_valid, 0);
        end
        check(out_valid == 1'b0 && ovf == 1'b1, "R3", "no extra event, ovf sticky",
              {out_valid, ovf}, 1);
        fire(8'd40, 1);
        read_event(0, "R5");
        check(ovf == 1'b1, "R3", "ovf still set", ovf, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_clamp();
        t_wrap();
        t_stall();
        t_order();
        t_overflow();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule